// File: doc/BRIEF.md
# Frame Delineation Receiver Checker

This block sits behind the capture stage of a source-synchronous parallel link receiver. The capture stage has already sampled the data pins on both edges of the link's reference clock. It hands this block one beat at a time in the receive clock domain. Each beat comes with the edge phase it was taken on and with the sampled level of the NRZ frame line. A change of the frame level from one beat to the next marks the first beat of a new packet, control symbol or idle symbol. Every such unit is aligned to 32 bits.

The block uses these frame-level changes to recover word alignment. It packs beats into 32-bit words and emits each word with a flag that says whether the word opened a new unit. At the same time it checks that the frame line changes only where the rules allow. It also checks that the reference phase alternates from beat to beat. Violations are reported as one-cycle error pulses for the link error-recovery logic. Decoding of symbols and packets, CRC checking and the recovery sequence itself belong elsewhere.

The beat width is a parameter: 8 bits gives four beats per word and 16 bits gives two. The default is 8.

Top module: `frame_delin_rx`

## Requirements
- R1: While reset is low, and on the first cycle after reset is released, `word_valid`, `word_start`, `synced`, `err_frame` and `err_phase` are all 0.
- R2: After reset, the first valid beat only records the frame level and the phase. Beats are discarded with no word output and `synced` low until the frame level changes between two valid beats.
- R3: A frame change on a beat with `beat_phase`=1 (rising edge) while unsynchronized sets `synced`. That beat becomes the first beat of a word, and the word is emitted with `word_start`=1.
- R4: Beats are packed first beat into bits [31:24] down to the last beat in bits [7:0]. `word_valid` is high for exactly one cycle, in the cycle after the clock edge that takes the last beat of the word.
- R5: A word whose first beat carries no frame change is emitted with `word_start`=0.
- R6: While synchronized, a frame change on any beat other than the first beat of a word raises `err_frame` for one cycle. The partial word is dropped (no `word_valid`), and `synced` falls. This also covers two changes less than 4 bytes apart.
- R7: A frame change on a beat with `beat_phase`=0 (falling edge) raises `err_frame` for one cycle, whether synchronized or not. It never starts alignment.
- R8: After a framing error, alignment is regained at the next legal frame change, as in R3.
- R9: Two consecutive valid beats with the same `beat_phase` raise `err_phase` for one cycle after the second beat. Word assembly is not affected.
- R10: Cycles with `beat_valid`=0 do not advance assembly, do not count as beats for the frame or phase comparisons, and produce no output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| beat_valid | input | 1 | A captured beat is present this cycle |
| beat_data | input | BEAT_W | Captured beat |
| beat_phase | input | 1 | 1: beat taken on rising reference edge, 0: falling |
| frame_lvl | input | 1 | Sampled frame line level for this beat |
| word_valid | output | 1 | One-cycle strobe: `word_data` holds a complete word |
| word_data | output | 32 | Reassembled word, first beat in the top byte |
| word_start | output | 1 | Word began with a frame change |
| synced | output | 1 | Word alignment is established |
| err_frame | output | 1 | One-cycle pulse: illegal frame change |
| err_phase | output | 1 | One-cycle pulse: reference phase did not alternate |

## Verification
Every result is one register stage behind the beat that causes it. The word strobe and its start flag follow the edge that takes the last beat. Both error pulses follow the edge that takes the offending beat. `synced` changes right after the edge that takes the locking or erroring beat. The bench drives each beat at a falling clock edge, lets one rising edge take it, and compares all outputs at the next falling edge. Each table row therefore holds the exact values due for the beat it applies. Idle rows confirm that pulses last one cycle and that gaps change nothing.

// File: rtl/fdr_pkg.sv
// Shared types for the frame delineation receiver.
package fdr_pkg;

    // Alignment state: hunting for a frame change, or locked to word boundaries.
    typedef enum logic {
        ALN_HUNT = 1'b0,
        ALN_LOCK = 1'b1
    } aln_state_e;

    localparam int unsigned WORD_BITS = 32;

endpackage

// File: rtl/fdr_line_monitor.sv
// fdr_line_monitor
// Watches the frame line and the reference phase across valid beats.
// Reports a combinational frame-change flag for the current beat and a
// registered one-cycle pulse when two beats in a row carry the same phase.
// Assumes: gaps (beat_valid low) are transparent; the first valid beat after
// reset only loads the reference values.
module fdr_line_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_valid,
    input  logic beat_phase,
    input  logic frame_lvl,
    output logic frame_chg,
    output logic err_phase
);

    logic ref_frame;
    logic ref_phase;
    logic have_ref;

    // Hold frame level and phase of the last valid beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_frame <= 1'b0;
            ref_phase <= 1'b0;
            have_ref  <= 1'b0;
        end else if (beat_valid) begin
            ref_frame <= frame_lvl;
            ref_phase <= beat_phase;
            have_ref  <= 1'b1;
        end
    end

    // A change is only meaningful once a reference beat exists.
    always_comb begin
        frame_chg = beat_valid && have_ref && (frame_lvl != ref_frame);
    end

    // Pulse when the phase fails to alternate between consecutive beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_phase <= 1'b0;
        end else begin
            err_phase <= beat_valid && have_ref && (beat_phase == ref_phase);
        end
    end

    // R9: a phase pulse is always caused by a beat in the previous cycle.
    a_r9_phase_needs_beat : assert property (@(posedge clk) disable iff (!rst_n)
        err_phase |-> $past(beat_valid));

endmodule

// File: rtl/fdr_align_ctl.sv
// fdr_align_ctl
// Alignment state machine. Hunts for a legal frame change, then counts beat
// slots within each word. Flags frame changes on a non-first slot or on a
// falling-phase beat, drops the current word and returns to hunting.
// Assumes: BEATS >= 2, so the first and last slot of a word never coincide.
module fdr_align_ctl
    import fdr_pkg::*;
#(
    parameter int unsigned BEATS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         beat_valid,
    input  logic                         beat_phase,
    input  logic                         frame_chg,
    output logic                         take,
    output logic [$clog2(BEATS)-1:0]     slot,
    output logic                         last,
    output logic                         start_bit,
    output logic                         synced,
    output logic                         err_frame
);

    localparam int unsigned IDX_W = $clog2(BEATS);
    localparam logic [IDX_W-1:0] SLOT_LAST = IDX_W'(BEATS - 1);

    aln_state_e       state_q, state_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic             start_q, start_n;
    logic             err_n;

    // Next-state decision for every valid beat.
    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        start_n = start_q;
        err_n   = 1'b0;
        take    = 1'b0;
        if (beat_valid) begin
            unique case (state_q)
                ALN_HUNT: begin
                    if (frame_chg) begin
                        if (beat_phase) begin
                            state_n = ALN_LOCK;
                            take    = 1'b1;
                            idx_n   = IDX_W'(1);
                            start_n = 1'b1;
                        end else begin
                            err_n = 1'b1;
                        end
                    end
                end
                ALN_LOCK: begin
                    if (frame_chg && ((idx_q != '0) || !beat_phase)) begin
                        err_n   = 1'b1;
                        state_n = ALN_HUNT;
                        idx_n   = '0;
                        start_n = 1'b0;
                    end else begin
                        take = 1'b1;
                        if (idx_q == '0) begin
                            start_n = frame_chg;
                        end
                        idx_n = (idx_q == SLOT_LAST) ? '0 : idx_q + IDX_W'(1);
                    end
                end
                default: begin
                    state_n = ALN_HUNT;
                end
            endcase
        end
    end

    // Slot of the current beat: a locking beat always lands in slot zero.
    always_comb begin
        slot      = (state_q == ALN_HUNT) ? '0 : idx_q;
        last      = take && (slot == SLOT_LAST);
        start_bit = start_q;
    end

    // State, slot counter and start flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ALN_HUNT;
            idx_q   <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            start_q <= start_n;
        end
    end

    // One-cycle framing error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_frame <= 1'b0;
        end else begin
            err_frame <= err_n;
        end
    end

    assign synced = (state_q == ALN_LOCK);

    // R6: a framing error always leaves the block unsynchronized.
    a_r6_err_leaves_lock : assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |-> !synced);

    // R3: lock is gained only on a valid rising-phase beat with a frame change.
    a_r3_lock_on_rising : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced) |-> $past(beat_valid && beat_phase && frame_chg));

    // R7: no frame change on a falling-phase beat is ever taken.
    a_r7_no_falling_take : assert property (@(posedge clk) disable iff (!rst_n)
        (take && frame_chg) |-> beat_phase);

    // R10: the slot counter is frozen during gaps.
    a_r10_gap_holds_slot : assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid && synced) |=> $stable(idx_q));

endmodule

// File: rtl/fdr_word_pack.sv
// fdr_word_pack
// Places each taken beat into its slot of a 32-bit word, first slot in the
// most significant bits, and emits the word with its start flag when the last
// slot arrives. Assumes: every slot is written before the last slot, so a
// dropped partial word needs no clearing; stale slots are always overwritten.
module fdr_word_pack
    import fdr_pkg::*;
#(
    parameter int unsigned BEAT_W = 8,
    parameter int unsigned BEATS  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         take,
    input  logic [$clog2(BEATS)-1:0]     slot,
    input  logic                         last,
    input  logic                         start_bit,
    input  logic [BEAT_W-1:0]            beat_data,
    output logic                         word_valid,
    output logic [WORD_BITS-1:0]         word_data,
    output logic                         word_start
);

    logic [WORD_BITS-1:0] acc_q;
    logic [WORD_BITS-1:0] acc_n;

    // Merge the incoming beat into its slot, one lane per slot.
    for (genvar k = 0; k < BEATS; k++) begin : g_lane
        localparam int unsigned HI = WORD_BITS - 1 - k * BEAT_W;
        always_comb begin
            acc_n[HI -: BEAT_W] = (take && (slot == k)) ? beat_data : acc_q[HI -: BEAT_W];
        end
    end

    // Accumulator for the word under assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_n;
        end
    end

    // Output register: strobe, word and start flag on the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
            word_start <= 1'b0;
        end else begin
            word_valid <= last;
            if (last) begin
                word_data  <= acc_n;
                word_start <= start_bit;
            end
        end
    end

    // R4: the word strobe never lasts two cycles.
    a_r4_strobe_single : assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

endmodule

// File: rtl/frame_delin_rx.sv
// frame_delin_rx
// Top of the frame delineation receiver checker. Rebuilds 32-bit words from
// double-edge captured beats, marks unit starts from NRZ frame-line changes
// and reports illegal frame changes and non-alternating reference phase.
// Assumes: beats already in the receive clock domain; BEAT_W is 8 or 16.
module frame_delin_rx
    import fdr_pkg::*;
#(
    parameter int unsigned BEAT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   beat_valid,
    input  logic [BEAT_W-1:0]      beat_data,
    input  logic                   beat_phase,
    input  logic                   frame_lvl,
    output logic                   word_valid,
    output logic [WORD_BITS-1:0]   word_data,
    output logic                   word_start,
    output logic                   synced,
    output logic                   err_frame,
    output logic                   err_phase
);

    localparam int unsigned BEATS = WORD_BITS / BEAT_W;
    localparam int unsigned IDX_W = $clog2(BEATS);

    logic             frame_chg;
    logic             take;
    logic [IDX_W-1:0] slot;
    logic             last;
    logic             start_bit;

    fdr_line_monitor u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .beat_phase (beat_phase),
        .frame_lvl  (frame_lvl),
        .frame_chg  (frame_chg),
        .err_phase  (err_phase)
    );

    fdr_align_ctl #(.BEATS(BEATS)) u_aln (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .beat_phase (beat_phase),
        .frame_chg  (frame_chg),
        .take       (take),
        .slot       (slot),
        .last       (last),
        .start_bit  (start_bit),
        .synced     (synced),
        .err_frame  (err_frame)
    );

    fdr_word_pack #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .slot       (slot),
        .last       (last),
        .start_bit  (start_bit),
        .beat_data  (beat_data),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_start (word_start)
    );

    // R2: a word is only emitted when alignment held at the taking edge.
    a_r2_word_needs_lock : assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(synced));

    // R6: an erroring beat never completes a word.
    a_r6_no_word_on_error : assert property (@(posedge clk) disable iff (!rst_n)
        !(err_frame && word_valid));

endmodule

// File: tb/frame_delin_rx_tb.sv
module frame_delin_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 27;

    typedef struct packed {
        logic        v;
        logic [7:0]  d;
        logic        p;
        logic        f;
        logic        wv;
        logic [31:0] w;
        logic        st;
        logic        sy;
        logic        ef;
        logic        ep;
    } vec_t;

    // Each row: beat inputs, then outputs due one edge later.
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 reference beat
        '{1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 discard
        '{1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'hA1, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 lock
        '{1'b1, 8'hA2, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'hA3, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'hA4, 1'b0, 1'b1, 1'b1, 32'hA1A2A3A4, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 R3
        '{1'b1, 8'hB1, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'hB2, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 8'hEE, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0}, // R10 gap
        '{1'b1, 8'hB3, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'hB4, 1'b0, 1'b1, 1'b1, 32'hB1B2B3B4, 1'b0, 1'b1, 1'b0, 1'b0}, // R5
        '{1'b1, 8'hC1, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'hC2, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6
        '{1'b1, 8'hD1, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'hD2, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 hunting
        '{1'b1, 8'hE1, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 relock
        '{1'b1, 8'hE2, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'hE3, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1}, // R9
        '{1'b1, 8'hE4, 1'b1, 1'b1, 1'b1, 32'hE1E2E3E4, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 no effect
        '{1'b1, 8'hF1, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 locked
        '{1'b1, 8'h51, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8
        '{1'b1, 8'h52, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'h53, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'h54, 1'b0, 1'b1, 1'b1, 32'h51525354, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0}  // R4 single strobe
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        beat_valid = 1'b0;
    logic [7:0]  beat_data = '0;
    logic        beat_phase = 1'b0;
    logic        frame_lvl = 1'b0;
    logic        word_valid;
    logic [31:0] word_data;
    logic        word_start;
    logic        synced;
    logic        err_frame;
    logic        err_phase;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frame_delin_rx #(.BEAT_W(8)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .beat_data  (beat_data),
        .beat_phase (beat_phase),
        .frame_lvl  (frame_lvl),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_start (word_start),
        .synced     (synced),
        .err_frame  (err_frame),
        .err_phase  (err_phase)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] d, input logic p, input logic f);
        beat_valid = v;
        beat_data  = d;
        beat_phase = p;
        frame_lvl  = f;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        check(req, "word_valid", {31'b0, word_valid}, 32'd0);
        check(req, "word_start", {31'b0, word_start}, 32'd0);
        check(req, "synced", {31'b0, synced}, 32'd0);
        check(req, "err_frame", {31'b0, err_frame}, 32'd0);
        check(req, "err_phase", {31'b0, err_phase}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: outputs held low in reset and just after release.
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_idle("R1");

        // Table walk: each row's outputs are due one edge after its beat.
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].v, VEC[i].d, VEC[i].p, VEC[i].f);
            check("R4", "word_valid", {31'b0, word_valid}, {31'b0, VEC[i].wv});
            if (VEC[i].wv) begin
                check("R4", "word_data", word_data, VEC[i].w);
                check("R3 R5", "word_start", {31'b0, word_start}, {31'b0, VEC[i].st});
            end
            check("R2 R8", "synced", {31'b0, synced}, {31'b0, VEC[i].sy});
            check("R6 R7", "err_frame", {31'b0, err_frame}, {31'b0, VEC[i].ef});
            check("R9", "err_phase", {31'b0, err_phase}, {31'b0, VEC[i].ep});
        end

        // R1: reset while locked clears everything.
        rst_n = 1'b0;
        drive(1'b0, 8'h00, 1'b0, 1'b0);
        check_idle("R1");
        rst_n = 1'b1;

        // R2: first beat after reset has frame high but is only a reference.
        drive(1'b1, 8'h61, 1'b1, 1'b1);
        check_idle("R2");
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, 8'h62, (k % 2 == 0) ? 1'b0 : 1'b1, 1'b1);
            check_idle("R2");
        end

        // R10: gaps inside a word do not disturb assembly or phase tracking.
        drive(1'b1, 8'h71, 1'b1, 1'b0);
        check("R3", "synced", {31'b0, synced}, 32'd1);
        drive(1'b0, 8'hFF, 1'b1, 1'b1);
        drive(1'b0, 8'hFF, 1'b1, 1'b1);
        check("R10", "err_phase", {31'b0, err_phase}, 32'd0);
        check("R10", "err_frame", {31'b0, err_frame}, 32'd0);
        drive(1'b1, 8'h72, 1'b0, 1'b0);
        drive(1'b1, 8'h73, 1'b1, 1'b0);
        drive(1'b0, 8'hFF, 1'b0, 1'b1);
        drive(1'b1, 8'h74, 1'b0, 1'b0);
        check("R10", "word_valid", {31'b0, word_valid}, 32'd1);
        check("R10", "word_data", word_data, 32'h71727374);
        check("R3", "word_start", {31'b0, word_start}, 32'd1);
        check("R10", "err_phase", {31'b0, err_phase}, 32'd0);

        // R6: two changes only two bytes apart.
        drive(1'b1, 8'h81, 1'b1, 1'b1);
        drive(1'b1, 8'h82, 1'b0, 1'b1);
        drive(1'b1, 8'h83, 1'b1, 1'b0);
        check("R6", "err_frame", {31'b0, err_frame}, 32'd1);
        check("R6", "synced", {31'b0, synced}, 32'd0);
        drive(1'b1, 8'h84, 1'b0, 1'b0);
        check("R6", "err_frame pulse", {31'b0, err_frame}, 32'd0);
        check("R6", "word_valid", {31'b0, word_valid}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule